// File: doc/BRIEF.md
# Boot Command Sequencer with Sector Address Generator

This block sits behind the host write port of a flash device that has a small on-chip boot buffer. Host writes that land in the boot-buffer window are read as boot commands: a warm reset, a two-write page-load sequence and an identification read. The identification read places the manufacturer code, the device code and the write-protection status into the first three buffer words. A page load asks an external array controller, through a request/acknowledge pair, to copy one full 2 KB page (four 512-byte sectors) into data buffer 0. When that copy is acknowledged, the page register moves forward by four sectors, so that repeated loads walk through the array.

The block also keeps the block and page start-address registers and turns them into a linear 512-byte sector number. For large devices, the top bit of the block register folds a density-dependent bit into the block field. It supplies the first sector of the block that an erase would clear. It also decodes the start-buffer register into a buffer index and a sector count, and forms that register's read-back value.

Top module: `boot_cmd_seq`

## Requirements
- R1: A write is a boot command only when its word offset lies in 0x0000–0x01FF or in 0x8000–0x800F. An idle boot write whose value is not 0x00F0, 0x00E0 or 0x0090 changes nothing. A write of any value at an offset outside these windows and outside the register offsets 0xF100, 0xF107 and 0xF200 changes nothing.
- R2: In the idle state, boot value 0x00F0 acts on the same edge. It clears the block and page registers and sets buffer index 0 and sector count 1. It discards any armed load, outstanding load request and identification sequence. `warm_rst` is high for exactly the following cycle.
- R3: In the idle state, boot value 0x00E0 arms a load. The next boot write, whatever its value (0x00F0 included), ends the armed state and performs no other boot command.
- R4: An armed boot write of 0x0000, made while no request is outstanding, raises `ld_req` from the next cycle. `ld_sector` then holds the sector number of the registers as they were before that edge. Both stay unchanged until a cycle with `ld_ack` high. An armed 0x0000 made while a request is outstanding starts no new request.
- R5: On an edge where `ld_req` and `ld_ack` are both high, the request drops and the 8-bit page register advances by 4 modulo 256. A host write to the page register (offset 0xF107) on the same edge takes precedence, and the increment is lost.
- R6: Idle boot value 0x0090 starts three consecutive cycles with `idw_en` high and `idw_addr` set to 0, 1 and 2. The data words are {8'h00, man_id}, {8'h00, dev_id} and {8'h00, wp_status}. A new 0x0090 restarts the sequence at word 0.
- R7: `sector_num` is the concatenation {folded_block[13:0], page[7:2], page[1:0]}. folded_block is block[11:0] OR'ed with the density mask when block bit 15 is set.
- R8: The density mask is 1 << (6 + dev_id[6:4]) when dev_id bit 3 is set, and 0 otherwise.
- R9: A write to offset 0xF200 sets the buffer index to value[11:8] and the sector count to value[1:0], where 0 stands for 4. `sbuf_rd` returns (index << 8) | ((count − 1) & 2).
- R10: `erase_sector` is folded_block << 8, the first of the block's 256 sectors.
- R11: Synchronous reset gives the same register state as a warm reset, with `ld_sector` cleared and `warm_rst` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host write word offset |
| wr_data | input | 16 | Host write value |
| man_id | input | 8 | Manufacturer code, low byte |
| dev_id | input | 8 | Device code, low byte (bits 6:3 select density) |
| wp_status | input | 8 | Write-protection status, low byte |
| ld_ack | input | 1 | Array controller accepts the page load |
| ld_req | output | 1 | Page-load request to the array controller |
| ld_sector | output | 22 | First sector of the requested page |
| idw_en | output | 1 | Boot-buffer word write strobe for identification |
| idw_addr | output | 2 | Boot-buffer word index |
| idw_data | output | 16 | Boot-buffer word value |
| warm_rst | output | 1 | One-cycle pulse after a warm reset |
| block_q | output | 16 | Block start-address register |
| page_q | output | 8 | Page start-address register |
| sector_num | output | 22 | Linear sector number from block and page |
| erase_sector | output | 22 | First sector of the addressed block |
| buf_idx | output | 4 | Decoded buffer index |
| sec_count | output | 3 | Decoded sector count (1 to 4) |
| sbuf_rd | output | 16 | Start-buffer read-back value |

## Verification
Two pairs of functions can coincide in one cycle. The page-load acknowledge can meet a host write to the page register, and it can also meet a warm-reset boot write. The bench holds a request open with `ld_ack` low, then raises the acknowledge on the same cycle as a 0xF107 write, and on another run on the same cycle as a 0x00F0 boot write. The cycle-level model predicts that the written page value survives the first case and that the cleared state survives the second. The bench also overlaps an armed load with an identification sequence, and an outstanding request with a second armed 0x0000, and compares every output on every clock.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int PAGE_W    = 8;
    localparam int SUB_W     = 2;
    localparam int PIB_W     = PAGE_W - SUB_W;
    localparam int BLK_W     = 16;
    localparam int BLK_LOW_W = 12;
    localparam int FOLD_W    = 14;
    localparam int SECT_W    = FOLD_W + PIB_W + SUB_W;
    localparam int ERASE_SH  = PIB_W + SUB_W;
    localparam int BIDX_W    = 4;
    localparam int CNT_W     = 3;
    localparam int CSEL_W    = 2;
    localparam int IDW_N     = 3;
    localparam int IDA_W     = 2;
    localparam int MASK_BASE = 6;

    localparam logic [PAGE_W-1:0] PAGE_STEP = PAGE_W'(1 << SUB_W);
    localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(1 << SUB_W);
    localparam logic [CNT_W-1:0]  CNT_RST   = CNT_W'(1);

    // host word offsets decoded by this block
    localparam logic [ADDR_W-1:0] BOOT_LO_END  = 16'h01FF;
    localparam logic [ADDR_W-1:0] BOOT_HI_BASE = 16'h8000;
    localparam logic [ADDR_W-1:0] BOOT_HI_END  = 16'h800F;
    localparam logic [ADDR_W-1:0] OFS_BLOCK    = 16'hF100;
    localparam logic [ADDR_W-1:0] OFS_PAGE     = 16'hF107;
    localparam logic [ADDR_W-1:0] OFS_SBUF     = 16'hF200;

    // boot command values
    localparam logic [DATA_W-1:0] BC_WRESET = 16'h00F0;
    localparam logic [DATA_W-1:0] BC_ARM    = 16'h00E0;
    localparam logic [DATA_W-1:0] BC_IDENT  = 16'h0090;
    localparam logic [DATA_W-1:0] BC_GO     = 16'h0000;

    typedef struct packed {
        logic [BLK_W-1:0]  block;
        logic [PAGE_W-1:0] page;
    } start_addr_t;

    typedef struct packed {
        logic [BIDX_W-1:0] idx;
        logic [CNT_W-1:0]  cnt;
    } sbuf_t;

    typedef enum logic [0:0] {
        SQ_IDLE  = 1'b0,
        SQ_ARMED = 1'b1
    } seq_state_e;

    function automatic logic in_boot_window(input logic [ADDR_W-1:0] a);
        return (a <= BOOT_LO_END) || ((a >= BOOT_HI_BASE) && (a <= BOOT_HI_END));
    endfunction

    function automatic logic [FOLD_W-1:0] density_mask(input logic en,
                                                       input logic [2:0] sel);
        logic [3:0] sh;
        sh = 4'(MASK_BASE) + {1'b0, sel};
        return en ? (FOLD_W'(1) << sh) : '0;
    endfunction

    function automatic logic [FOLD_W-1:0] fold_block(input logic [BLK_LOW_W-1:0] low,
                                                     input logic ext,
                                                     input logic [FOLD_W-1:0] mask);
        return FOLD_W'(low) | (ext ? mask : '0);
    endfunction

    function automatic logic [CNT_W-1:0] decode_count(input logic [CSEL_W-1:0] v);
        return (v == '0) ? CNT_FULL : CNT_W'(v);
    endfunction

    function automatic logic [DATA_W-1:0] sbuf_readback(input sbuf_t s);
        logic [CNT_W-1:0] m1;
        m1 = s.cnt - CNT_W'(1);
        return DATA_W'({s.idx, 8'h00}) | DATA_W'(m1 & CNT_W'(2));
    endfunction

endpackage

// File: rtl/bseq_addr_regs.sv
module bseq_addr_regs
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              page_bump,
    output start_addr_t       sa
);

    logic block_wr;
    logic page_wr;

    assign block_wr = we && (addr == OFS_BLOCK);
    assign page_wr  = we && (addr == OFS_PAGE);

    always_ff @(posedge clk) begin
        if (rst || warm) begin
            sa <= '0;
        end else begin
            if (block_wr) begin
                sa.block <= data;
            end
            // a host write to the page register wins over the load increment
            if (page_wr) begin
                sa.page <= data[PAGE_W-1:0];
            end else if (page_bump) begin
                sa.page <= sa.page + PAGE_STEP;
            end
        end
    end

endmodule

// File: rtl/bseq_bufcfg.sv
module bseq_bufcfg
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BIDX_W-1:0] val_idx,
    input  logic [CSEL_W-1:0] val_cnt,
    output sbuf_t             cfg,
    output logic [DATA_W-1:0] rd_val
);

    always_ff @(posedge clk) begin
        if (rst || warm) begin
            cfg.idx <= '0;
            cfg.cnt <= CNT_RST;
        end else if (we && (addr == OFS_SBUF)) begin
            cfg.idx <= val_idx;
            cfg.cnt <= decode_count(val_cnt);
        end
    end

    assign rd_val = sbuf_readback(cfg);

endmodule

// File: rtl/bseq_sector_calc.sv
module bseq_sector_calc
    import bseq_pkg::*;
(
    input  logic [BLK_LOW_W-1:0] blk_low,
    input  logic                 blk_ext,
    input  logic [PAGE_W-1:0]    page,
    input  logic                 dens_en,
    input  logic [2:0]           dens_sel,
    output logic [SECT_W-1:0]    sector,
    output logic [SECT_W-1:0]    erase_first
);

    logic [FOLD_W-1:0] mask;
    logic [FOLD_W-1:0] folded;

    assign mask   = density_mask(dens_en, dens_sel);
    assign folded = fold_block(blk_low, blk_ext, mask);

    // page[7:2] is below 64, so the shifted sum is a plain concatenation
    assign sector      = {folded, page[PAGE_W-1:SUB_W], page[SUB_W-1:0]};
    assign erase_first = {folded, {ERASE_SH{1'b0}}};

endmodule

// File: rtl/bseq_boot_fsm.sv
module bseq_boot_fsm
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [BYTE_W-1:0] man_id,
    input  logic [BYTE_W-1:0] dev_id,
    input  logic [BYTE_W-1:0] wp_status,
    input  logic [SECT_W-1:0] cur_sector,
    input  logic              ld_ack,
    output logic              warm_hit,
    output logic              page_bump,
    output logic              ld_req,
    output logic [SECT_W-1:0] ld_sector,
    output logic              idw_en,
    output logic [IDA_W-1:0]  idw_addr,
    output logic [DATA_W-1:0] idw_data,
    output logic              warm_rst
);

    seq_state_e       state;
    logic             boot_wr;
    logic             go_hit;
    logic             id_hit;
    logic             id_busy;
    logic [IDA_W-1:0] id_ptr;
    logic [DATA_W-1:0] id_words [IDW_N];

    assign boot_wr   = we && in_boot_window(addr);
    assign warm_hit  = boot_wr && (state == SQ_IDLE) && (data == BC_WRESET);
    assign go_hit    = boot_wr && (state == SQ_ARMED) && (data == BC_GO) && !ld_req;
    assign id_hit    = boot_wr && (state == SQ_IDLE) && (data == BC_IDENT);
    assign page_bump = ld_req && ld_ack && !warm_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            ld_req    <= 1'b0;
            ld_sector <= '0;
            id_busy   <= 1'b0;
            id_ptr    <= '0;
            warm_rst  <= 1'b0;
        end else begin
            warm_rst <= warm_hit;
            if (warm_hit) begin
                state   <= SQ_IDLE;
                ld_req  <= 1'b0;
                id_busy <= 1'b0;
                id_ptr  <= '0;
            end else begin
                if (boot_wr) begin
                    state <= ((state == SQ_IDLE) && (data == BC_ARM)) ? SQ_ARMED : SQ_IDLE;
                end
                if (go_hit) begin
                    ld_req    <= 1'b1;
                    ld_sector <= cur_sector;
                end else if (ld_req && ld_ack) begin
                    ld_req <= 1'b0;
                end
                if (id_hit) begin
                    id_busy <= 1'b1;
                    id_ptr  <= '0;
                end else if (id_busy) begin
                    if (id_ptr == IDA_W'(IDW_N - 1)) begin
                        id_busy <= 1'b0;
                        id_ptr  <= '0;
                    end else begin
                        id_ptr <= id_ptr + IDA_W'(1);
                    end
                end
            end
        end
    end

    // identification words: upper byte cleared, low byte from the source
    generate
        for (genvar w = 0; w < IDW_N; w++) begin : g_idw
            logic [BYTE_W-1:0] src;
            if (w == 0) begin : g_man
                assign src = man_id;
            end else if (w == 1) begin : g_dev
                assign src = dev_id;
            end else begin : g_wp
                assign src = wp_status;
            end
            assign id_words[w] = {{(DATA_W-BYTE_W){1'b0}}, src};
        end
    endgenerate

    always_comb begin
        idw_data = '0;
        for (int k = 0; k < IDW_N; k++) begin
            if (id_ptr == IDA_W'(k)) begin
                idw_data = id_words[k];
            end
        end
    end

    assign idw_en   = id_busy;
    assign idw_addr = id_ptr;

endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] man_id,
    input  logic [BYTE_W-1:0] dev_id,
    input  logic [BYTE_W-1:0] wp_status,
    input  logic              ld_ack,
    output logic              ld_req,
    output logic [SECT_W-1:0] ld_sector,
    output logic              idw_en,
    output logic [IDA_W-1:0]  idw_addr,
    output logic [DATA_W-1:0] idw_data,
    output logic              warm_rst,
    output logic [BLK_W-1:0]  block_q,
    output logic [PAGE_W-1:0] page_q,
    output logic [SECT_W-1:0] sector_num,
    output logic [SECT_W-1:0] erase_sector,
    output logic [BIDX_W-1:0] buf_idx,
    output logic [CNT_W-1:0]  sec_count,
    output logic [DATA_W-1:0] sbuf_rd
);

    start_addr_t sa;
    sbuf_t       cfg;
    logic        warm_hit;
    logic        page_bump;
    logic        page_wr;

    assign page_wr = wr_en && (wr_addr == OFS_PAGE);

    bseq_boot_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .we         (wr_en),
        .addr       (wr_addr),
        .data       (wr_data),
        .man_id     (man_id),
        .dev_id     (dev_id),
        .wp_status  (wp_status),
        .cur_sector (sector_num),
        .ld_ack     (ld_ack),
        .warm_hit   (warm_hit),
        .page_bump  (page_bump),
        .ld_req     (ld_req),
        .ld_sector  (ld_sector),
        .idw_en     (idw_en),
        .idw_addr   (idw_addr),
        .idw_data   (idw_data),
        .warm_rst   (warm_rst)
    );

    bseq_addr_regs u_addr (
        .clk       (clk),
        .rst       (rst),
        .warm      (warm_hit),
        .we        (wr_en),
        .addr      (wr_addr),
        .data      (wr_data),
        .page_bump (page_bump),
        .sa        (sa)
    );

    bseq_bufcfg u_buf (
        .clk     (clk),
        .rst     (rst),
        .warm    (warm_hit),
        .we      (wr_en),
        .addr    (wr_addr),
        .val_idx (wr_data[11:8]),
        .val_cnt (wr_data[CSEL_W-1:0]),
        .cfg     (cfg),
        .rd_val  (sbuf_rd)
    );

    bseq_sector_calc u_sec (
        .blk_low     (sa.block[BLK_LOW_W-1:0]),
        .blk_ext     (sa.block[BLK_W-1]),
        .page        (sa.page),
        .dens_en     (dev_id[3]),
        .dens_sel    (dev_id[6:4]),
        .sector      (sector_num),
        .erase_first (erase_sector)
    );

    assign block_q   = sa.block;
    assign page_q    = sa.page;
    assign buf_idx   = cfg.idx;
    assign sec_count = cfg.cnt;

endmodule

// File: rtl/bseq_checker.sv
module bseq_checker
    import bseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              warm_hit,
    input logic              page_wr,
    input logic [PAGE_W-1:0] wr_page_val,
    input logic              ld_req,
    input logic              ld_ack,
    input logic [SECT_W-1:0] ld_sector,
    input logic [PAGE_W-1:0] page_q,
    input logic [BLK_W-1:0]  block_q,
    input logic [CNT_W-1:0]  sec_count,
    input logic              idw_en,
    input logic [IDA_W-1:0]  idw_addr,
    input logic              warm_rst
);

    // R4: an open request and its sector stay put until acknowledged
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !ld_ack && !warm_hit) |=> (ld_req && $stable(ld_sector)));

    // R5: acknowledge advances the page by one page step
    p_page_bump_r5: assert property (@(posedge clk) disable iff (rst)
        (ld_req && ld_ack && !warm_hit && !page_wr) |=> (page_q == $past(page_q) + PAGE_STEP));

    // R5: host page write beats the increment
    p_host_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (ld_req && ld_ack && page_wr && !warm_hit) |=> (page_q == $past(wr_page_val)));

    // R2: warm reset leaves the cleared state behind it
    p_warm_state_r2: assert property (@(posedge clk) disable iff (rst)
        warm_rst |-> (block_q == '0 && page_q == '0 && sec_count == CNT_RST && !ld_req && !idw_en));

    // R6: identification writes start at word 0 and stay within three words
    p_id_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(idw_en) |-> (idw_addr == '0));

    p_id_range_r6: assert property (@(posedge clk) disable iff (rst)
        idw_en |-> (idw_addr < IDA_W'(IDW_N)));

    // R9: decoded count is always one to four sectors
    p_count_range_r9: assert property (@(posedge clk) disable iff (rst)
        (sec_count != '0) && (sec_count <= CNT_FULL));

endmodule

bind boot_cmd_seq bseq_checker u_bseq_checker (
    .clk         (clk),
    .rst         (rst),
    .warm_hit    (warm_hit),
    .page_wr     (page_wr),
    .wr_page_val (wr_data[7:0]),
    .ld_req      (ld_req),
    .ld_ack      (ld_ack),
    .ld_sector   (ld_sector),
    .page_q      (page_q),
    .block_q     (block_q),
    .sec_count   (sec_count),
    .idw_en      (idw_en),
    .idw_addr    (idw_addr),
    .warm_rst    (warm_rst)
);

// File: tb/test_boot_cmd_seq.sv
`timescale 1ns/1ps
module test_boot_cmd_seq;

    logic        clk;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_addr;
    logic [15:0] wr_data;
    logic [7:0]  man_id;
    logic [7:0]  dev_id;
    logic [7:0]  wp_status;
    logic        ld_ack;
    logic        ld_req;
    logic [21:0] ld_sector;
    logic        idw_en;
    logic [1:0]  idw_addr;
    logic [15:0] idw_data;
    logic        warm_rst;
    logic [15:0] block_q;
    logic [7:0]  page_q;
    logic [21:0] sector_num;
    logic [21:0] erase_sector;
    logic [3:0]  buf_idx;
    logic [2:0]  sec_count;
    logic [15:0] sbuf_rd;

    boot_cmd_seq i_boot_cmd_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .man_id(man_id), .dev_id(dev_id), .wp_status(wp_status), .ld_ack(ld_ack),
        .ld_req(ld_req), .ld_sector(ld_sector), .idw_en(idw_en), .idw_addr(idw_addr),
        .idw_data(idw_data), .warm_rst(warm_rst), .block_q(block_q), .page_q(page_q),
        .sector_num(sector_num), .erase_sector(erase_sector), .buf_idx(buf_idx),
        .sec_count(sec_count), .sbuf_rd(sbuf_rd)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string cur_req = "R11";

    // behavioural reference state
    int m_block, m_page, m_armed, m_req, m_lsec, m_busy, m_ptr, m_bidx, m_cnt, m_wr;

    function automatic int dmask(int dev);
        if ((dev >> 3) & 1) return 1 << (6 + ((dev >> 4) & 7));
        return 0;
    endfunction

    function automatic int folded(int blk, int dev);
        return (blk & 'hFFF) | ((((blk >> 15) & 1) != 0) ? dmask(dev) : 0);
    endfunction

    function automatic int sect(int blk, int pg, int dev);
        return (pg % 4) + (((pg / 4) + folded(blk, dev) * 64) * 4);
    endfunction

    task automatic model_step();
        int boot, warm, go, idh, nsec, d;
        d = int'(wr_data);
        if (rst) begin
            m_block = 0; m_page = 0; m_armed = 0; m_req = 0; m_lsec = 0;
            m_busy = 0; m_ptr = 0; m_bidx = 0; m_cnt = 1; m_wr = 0;
            return;
        end
        boot = wr_en && ((wr_addr <= 16'h01FF) || (wr_addr >= 16'h8000 && wr_addr <= 16'h800F));
        warm = boot && !m_armed && (d == 'h00F0);
        go   = boot && m_armed && (d == 0) && !m_req;
        idh  = boot && !m_armed && (d == 'h0090);
        nsec = sect(m_block, m_page, int'(dev_id));
        if (warm) begin
            m_block = 0; m_page = 0; m_armed = 0; m_req = 0;
            m_busy = 0; m_ptr = 0; m_bidx = 0; m_cnt = 1;
        end else begin
            if (wr_en && wr_addr == 16'hF107) m_page = d & 255;
            else if (m_req && ld_ack) m_page = (m_page + 4) % 256;
            if (wr_en && wr_addr == 16'hF100) m_block = d;
            if (wr_en && wr_addr == 16'hF200) begin
                m_bidx = (d >> 8) & 15;
                m_cnt  = ((d & 3) == 0) ? 4 : (d & 3);
            end
            if (go) begin m_req = 1; m_lsec = nsec; end
            else if (m_req && ld_ack) m_req = 0;
            if (idh) begin m_busy = 1; m_ptr = 0; end
            else if (m_busy) begin
                if (m_ptr == 2) begin m_busy = 0; m_ptr = 0; end
                else m_ptr = m_ptr + 1;
            end
            if (boot) m_armed = (!m_armed && d == 'h00E0) ? 1 : 0;
        end
        m_wr = warm;
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int iw;
        chk("R2 warm_rst", 32'(warm_rst), 32'(m_wr));
        chk("R2 block_q", 32'(block_q), 32'(m_block));
        chk("R5 page_q", 32'(page_q), 32'(m_page));
        chk("R7 sector_num", 32'(sector_num), 32'(sect(m_block, m_page, int'(dev_id))));
        chk("R10 erase_sector", 32'(erase_sector), 32'(folded(m_block, int'(dev_id)) * 256));
        chk("R4 ld_req", 32'(ld_req), 32'(m_req));
        if (m_req) chk("R4 ld_sector", 32'(ld_sector), 32'(m_lsec));
        chk("R9 buf_idx", 32'(buf_idx), 32'(m_bidx));
        chk("R9 sec_count", 32'(sec_count), 32'(m_cnt));
        chk("R9 sbuf_rd", 32'(sbuf_rd), 32'((m_bidx << 8) | ((m_cnt - 1) & 2)));
        chk("R6 idw_en", 32'(idw_en), 32'(m_busy));
        if (m_busy) begin
            iw = (m_ptr == 0) ? int'(man_id) : (m_ptr == 1) ? int'(dev_id) : int'(wp_status);
            chk("R6 idw_addr", 32'(idw_addr), 32'(m_ptr));
            chk("R6 idw_data", 32'(idw_data), 32'(iw));
        end
    endtask

    task automatic cyc(input logic we, input logic [15:0] a, input logic [15:0] d, input logic ack);
        wr_en = we; wr_addr = a; wr_data = d; ld_ack = ack;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 16'h0, 1'b0);
    endtask

    initial begin
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; ld_ack = 0;
        man_id = 8'hEC; dev_id = 8'h38; wp_status = 8'h02;
        @(negedge clk);
        // R11: reset state
        cur_req = "R11";
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        rst = 0;
        idle(1);

        // R7, R8: sector from registers with and without the density fold
        cur_req = "R7";
        wr(16'hF100, 16'h0005); wr(16'hF107, 16'h000A);
        cur_req = "R8";
        wr(16'hF100, 16'h8003);
        dev_id = 8'h30; idle(1);            // mask off (bit 3 clear)
        dev_id = 8'h78; idle(1);            // mask 1<<13
        dev_id = 8'h38; idle(1);
        cur_req = "R10";
        wr(16'hF100, 16'h0FFF); idle(1);

        // R9: start-buffer decode and read-back
        cur_req = "R9";
        wr(16'hF200, 16'h0A03); wr(16'hF200, 16'h0100);
        wr(16'hF200, 16'h0F02); wr(16'hF200, 16'h0001);

        // R4, R5: load with delayed ack, page wraps
        cur_req = "R4";
        wr(16'hF100, 16'h0012); wr(16'hF107, 16'h00FE);
        wr(16'h0000, 16'h00E0); wr(16'h0010, 16'h0000);
        wr(16'hF107, 16'h0033);             // sector must not follow this
        wr(16'h8000, 16'h00E0); wr(16'h8001, 16'h0000); // armed go while busy: no new request
        idle(2);
        cur_req = "R5";
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);                    // ack without request: no effect
        wr(16'hF107, 16'h00FC);
        wr(16'h0000, 16'h00E0); wr(16'h0000, 16'h0000);
        cyc(0, 0, 0, 1);                    // wrap 0xFC -> 0x00

        // R5: ack collides with host page write
        wr(16'h0000, 16'h00E0); wr(16'h0000, 16'h0000);
        idle(1);
        cyc(1, 16'hF107, 16'h0041, 1);
        idle(1);

        // R3: armed state consumed by any boot write, F0 included
        cur_req = "R3";
        wr(16'h0000, 16'h00E0); wr(16'h0000, 16'h0005);
        wr(16'h0000, 16'h0000);             // idle 0000: nothing
        wr(16'h0000, 16'h00E0); wr(16'h0000, 16'h00F0);
        wr(16'h0000, 16'h00E0); wr(16'h0001, 16'h0090);
        idle(3);

        // R6: identification, with restart and overlap with arming
        cur_req = "R6";
        man_id = 8'h5A; dev_id = 8'h4C; wp_status = 8'h04;
        wr(16'h01FF, 16'h0090); idle(1);
        wr(16'h0000, 16'h0090); idle(4);
        wr(16'h0000, 16'h0090); wr(16'h0000, 16'h00E0); idle(3);
        wr(16'h0000, 16'h0001);

        // R1: windows and unknown values
        cur_req = "R1";
        wr(16'hF200, 16'h0302);
        wr(16'h0000, 16'h1234); wr(16'h0200, 16'h00F0);
        wr(16'h7FFF, 16'h00F0); wr(16'h8010, 16'h00F0);
        wr(16'hF101, 16'hFFFF); wr(16'hF106, 16'hFFFF);
        idle(1);
        wr(16'h800F, 16'h00E0); wr(16'h8010, 16'h0000); wr(16'h800F, 16'h0007);

        // R2: warm reset, also against an open request and its ack
        cur_req = "R2";
        wr(16'hF100, 16'h8123); wr(16'hF107, 16'h0055); wr(16'hF200, 16'h0502);
        wr(16'h8005, 16'h00F0); idle(1);
        wr(16'hF100, 16'h0044); wr(16'hF107, 16'h0011);
        wr(16'h0000, 16'h00E0); wr(16'h0000, 16'h0000);
        cyc(1, 16'h0000, 16'h00F0, 1);      // warm wins over ack
        idle(2);
        wr(16'h0000, 16'h0090);
        wr(16'h0000, 16'h00F0);             // aborts identification
        idle(2);

        // R11: synchronous reset mid-activity
        cur_req = "R11";
        wr(16'hF100, 16'h0077); wr(16'h0000, 16'h00E0); wr(16'h0000, 16'h0000);
        rst = 1; cyc(0, 0, 0, 0);
        rst = 0; idle(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule